// File: doc/BRIEF.md
# Memory-Stage Cipher Steering Unit

This unit sits between a pipeline's memory stage and its data memory and decides, for each instruction, whether the data goes straight to memory or passes through a 64-bit block cipher first. A store that carries the cipher flag and takes its value from the register file is sent to an external encryption engine. The 32-bit value is widened with zeros to a 64-bit block, and the full ciphertext block is written to the 8-byte-aligned location. A load that carries the cipher flag reads the aligned 64-bit block, sends it to an external decryption engine and hands the low 32 bits of the plaintext to write-back. Every other load or store behaves like a normal 32-bit access to one word lane of the 64-bit memory.

Both engines are reached through valid/ready request channels and return their result with a one-cycle valid pulse. While a cipher operation is in flight, the unit requests a pipeline stall. The request drops in the cycle the engine result arrives, so the instruction leaves the stage on that clock edge. The key, the address and the store value are captured in the first cycle the instruction is presented. The engines always see that captured key.

Top module: `mem_crypt_stage`

## Requirements
- R1: A store without the cipher condition completes in its first cycle with stall low. It issues one write to the aligned address, with byte enables 8'h0F and the word in bits [31:0] when address bit 2 is 0, or byte enables 8'hF0 and the word in bits [63:32] when address bit 2 is 1.
- R2: A load without the cipher flag issues a read of the aligned address in its first cycle with stall low. In the next cycle, wb_valid is high and wb_data holds the memory word of the lane chosen by address bit 2.
- R3: A store with the cipher flag set but its operand not from the register file is handled exactly as in R1, and the encryption engine receives no request.
- R4: A cipher store makes exactly one encryption request with block {32'h0, store word}. In the cycle enc_out_valid arrives, it issues one write of enc_out_block with byte enables 8'hFF to the aligned address.
- R5: A load with the cipher flag (regardless of operand source) reads the aligned block in its first cycle and makes exactly one decryption request with that block. One cycle after dec_out_valid, it presents wb_valid with the low 32 bits of dec_out_block.
- R6: For a cipher operation, stall is high from its first cycle up to, but not including, the cycle the engine result arrives. In that cycle stall is low. Stall is never high for other instructions.
- R7: Key, address and store word are captured in the instruction's first cycle. Later changes on those inputs do not affect cipher_key, the engine block or the write address.
- R8: An engine request (valid high, ready low) holds its valid and its block unchanged until accepted. At most one engine is requested at a time.
- R9: After reset: stall, wb_valid, mem_en and both engine request valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Memory-stage instruction present |
| req_load | input | 1 | Instruction is a load |
| req_store | input | 1 | Instruction is a store |
| req_crypt | input | 1 | Cipher flag of the instruction |
| req_src_reg | input | 1 | Store operand comes from the register file |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Store word |
| req_key | input | KEY_W | Key captured at decode |
| stall | output | 1 | Hold later instructions out of the stage |
| wb_valid | output | 1 | Load result valid |
| wb_data | output | WORD_W | Load result |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Aligned block address |
| mem_be | output | BLK_W/8 | Byte enables |
| mem_wdata | output | BLK_W | Write block |
| mem_rdata | input | BLK_W | Read block, one cycle after a read |
| enc_in_valid | output | 1 | Encryption request valid |
| enc_in_ready | input | 1 | Encryption engine accepts |
| enc_in_block | output | BLK_W | Plaintext block |
| enc_out_valid | input | 1 | Ciphertext pulse |
| enc_out_block | input | BLK_W | Ciphertext |
| dec_in_valid | output | 1 | Decryption request valid |
| dec_in_ready | input | 1 | Decryption engine accepts |
| dec_in_block | output | BLK_W | Ciphertext block |
| dec_out_valid | input | 1 | Plaintext pulse |
| dec_out_block | input | BLK_W | Plaintext |
| cipher_key | output | KEY_W | Key for both engines |

## Verification
The bench goes after lane selection on unaligned addresses, cipher stores whose address has low bits set, and stores that carry the cipher flag with a non-register operand. A design that got these wrong would write the wrong byte lanes, write ciphertext to a misaligned address, or send plaintext through the engine. It scrambles key, address and data during every stall, so a unit that read live inputs instead of captured ones writes a block that does not match the expected ciphertext. Engine backpressure and latency are varied, which exposes a stall that drops a cycle early or late (a lost or repeated instruction) and write-back data that appears in the wrong cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENC_REQ,
    ST_ENC_WAIT,
    ST_RD_WAIT,
    ST_DEC_REQ,
    ST_DEC_WAIT
  } mcs_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PLAIN_ST,
    OP_PLAIN_LD,
    OP_CRYPT_ST,
    OP_CRYPT_LD
  } mcs_op_e;

endpackage

// File: rtl/mcs_classify.sv
module mcs_classify
  import mcs_pkg::*;
(
  input  logic    valid,
  input  logic    is_load,
  input  logic    is_store,
  input  logic    crypt,
  input  logic    src_reg,
  output mcs_op_e op
);

  // Loads decrypt on the flag alone; stores need a register-file operand too.
  always_comb begin
    op = OP_NONE;
    if (valid) begin
      if (is_load)       op = crypt ? OP_CRYPT_LD : OP_PLAIN_LD;
      else if (is_store) op = (crypt && src_reg) ? OP_CRYPT_ST : OP_PLAIN_ST;
    end
  end

endmodule

// File: rtl/mcs_lane.sv
module mcs_lane #(
  parameter int WORD_W = 32,
  parameter int BLK_W  = 64,
  localparam int LANES  = BLK_W / WORD_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BPW    = WORD_W / 8,
  localparam int BE_W   = BLK_W / 8
) (
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [LANE_W-1:0] rd_lane,
  input  logic [BLK_W-1:0]  rd_block,
  output logic [BLK_W-1:0]  wr_block,
  output logic [BE_W-1:0]   wr_be,
  output logic [WORD_W-1:0] rd_word
);

  function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                  input logic [LANE_W-1:0] ln);
    return blk[ln*WORD_W +: WORD_W];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_block[g*WORD_W +: WORD_W] = wr_word;
    assign wr_be[g*BPW +: BPW]          = {BPW{wr_lane == LANE_W'(g)}};
  end

  assign rd_word = pick_word(rd_block, rd_lane);

endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mcs_op_e    op,
  input  logic       enc_in_ready,
  input  logic       enc_out_valid,
  input  logic       dec_in_ready,
  input  logic       dec_out_valid,
  output mcs_state_e state,
  output logic       capture,
  output logic       rd_capture,
  output logic       enc_req,
  output logic       dec_req,
  output logic       enc_done,
  output logic       dec_done,
  output logic       stall
);

  mcs_state_e state_q, state_d;

  assign state      = state_q;
  assign capture    = (state_q == ST_IDLE) &&
                      (op == OP_CRYPT_ST || op == OP_CRYPT_LD);
  assign rd_capture = (state_q == ST_RD_WAIT);
  assign enc_req    = (state_q == ST_ENC_REQ);
  assign dec_req    = (state_q == ST_DEC_REQ);
  assign enc_done   = (state_q == ST_ENC_WAIT) && enc_out_valid;
  assign dec_done   = (state_q == ST_DEC_WAIT) && dec_out_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (op == OP_CRYPT_ST)      state_d = ST_ENC_REQ;
        else if (op == OP_CRYPT_LD) state_d = ST_RD_WAIT;
      end
      ST_ENC_REQ:  if (enc_in_ready) state_d = ST_ENC_WAIT;
      ST_ENC_WAIT: if (enc_out_valid) state_d = ST_IDLE;
      ST_RD_WAIT:  state_d = ST_DEC_REQ;
      ST_DEC_REQ:  if (dec_in_ready) state_d = ST_DEC_WAIT;
      ST_DEC_WAIT: if (dec_out_valid) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // The final cycle of a cipher op releases the stage so it retires once.
  always_comb begin
    unique case (state_q)
      ST_IDLE:     stall = capture;
      ST_ENC_WAIT: stall = !enc_out_valid;
      ST_DEC_WAIT: stall = !dec_out_valid;
      default:     stall = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/mem_crypt_stage.sv
module mem_crypt_stage
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BLK_W  = 64,
  parameter int KEY_W  = 64,
  localparam int BE_W   = BLK_W / 8,
  localparam int OFF_W  = $clog2(BE_W),
  localparam int LANES  = BLK_W / WORD_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WOFF_W = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_load,
  input  logic              req_store,
  input  logic              req_crypt,
  input  logic              req_src_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [KEY_W-1:0]  req_key,
  output logic              stall,
  output logic              wb_valid,
  output logic [WORD_W-1:0] wb_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic [BLK_W-1:0]  mem_rdata,
  output logic              enc_in_valid,
  input  logic              enc_in_ready,
  output logic [BLK_W-1:0]  enc_in_block,
  input  logic              enc_out_valid,
  input  logic [BLK_W-1:0]  enc_out_block,
  output logic              dec_in_valid,
  input  logic              dec_in_ready,
  output logic [BLK_W-1:0]  dec_in_block,
  input  logic              dec_out_valid,
  input  logic [BLK_W-1:0]  dec_out_block,
  output logic [KEY_W-1:0]  cipher_key
);

  function automatic logic [ADDR_W-1:0] align_blk(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], OFF_W'(0)};
  endfunction

  function automatic logic [LANE_W-1:0] lane_of(input logic [ADDR_W-1:0] a);
    return a[WOFF_W +: LANE_W];
  endfunction

  function automatic logic [BLK_W-1:0] widen(input logic [WORD_W-1:0] w);
    return {{(BLK_W-WORD_W){1'b0}}, w};
  endfunction

  mcs_op_e    op;
  mcs_state_e state;
  logic       capture, rd_capture, enc_req, dec_req, enc_done, dec_done;

  // named internal events for the checker
  logic ev_plain_rd, ev_enc_done, ev_dec_done;

  logic [KEY_W-1:0]  key_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_q;
  logic [BLK_W-1:0]  blk_q;
  logic              plain_pend_q;
  logic [LANE_W-1:0] lane_q;
  logic              cwb_valid_q;
  logic [WORD_W-1:0] cwb_data_q;

  logic [BLK_W-1:0]  lane_block;
  logic [BE_W-1:0]   lane_be;
  logic [WORD_W-1:0] rd_word;

  mcs_classify u_classify (
    .valid    (req_valid),
    .is_load  (req_load),
    .is_store (req_store),
    .crypt    (req_crypt),
    .src_reg  (req_src_reg),
    .op       (op)
  );

  mcs_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .op            (op),
    .enc_in_ready  (enc_in_ready),
    .enc_out_valid (enc_out_valid),
    .dec_in_ready  (dec_in_ready),
    .dec_out_valid (dec_out_valid),
    .state         (state),
    .capture       (capture),
    .rd_capture    (rd_capture),
    .enc_req       (enc_req),
    .dec_req       (dec_req),
    .enc_done      (enc_done),
    .dec_done      (dec_done),
    .stall         (stall)
  );

  mcs_lane #(.WORD_W(WORD_W), .BLK_W(BLK_W)) u_lane (
    .wr_lane  (lane_of(req_addr)),
    .wr_word  (req_wdata),
    .rd_lane  (lane_q),
    .rd_block (mem_rdata),
    .wr_block (lane_block),
    .wr_be    (lane_be),
    .rd_word  (rd_word)
  );

  assign ev_plain_rd = (state == ST_IDLE) && (op == OP_PLAIN_LD);
  assign ev_enc_done = enc_done;
  assign ev_dec_done = dec_done;

  // Memory port steering: plaintext lane access, cipher read, or ciphertext write.
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = align_blk(req_addr);
    mem_be    = lane_be;
    mem_wdata = lane_block;
    if (state == ST_IDLE) begin
      unique case (op)
        OP_PLAIN_ST: begin mem_en = 1'b1; mem_we = 1'b1; end
        OP_PLAIN_LD,
        OP_CRYPT_LD: mem_en = 1'b1;
        default: ;
      endcase
    end else if (enc_done) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = align_blk(addr_q);
      mem_be    = '1;
      mem_wdata = enc_out_block;
    end
  end

  assign enc_in_valid = enc_req;
  assign enc_in_block = widen(word_q);
  assign dec_in_valid = dec_req;
  assign dec_in_block = blk_q;
  assign cipher_key   = key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      addr_q <= '0;
      word_q <= '0;
    end else if (capture) begin
      key_q  <= req_key;
      addr_q <= req_addr;
      word_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blk_q <= '0;
    else if (rd_capture) blk_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_pend_q <= 1'b0;
      lane_q       <= '0;
      cwb_valid_q  <= 1'b0;
      cwb_data_q   <= '0;
    end else begin
      plain_pend_q <= ev_plain_rd;
      if (ev_plain_rd) lane_q <= lane_of(req_addr);
      cwb_valid_q  <= dec_done;
      if (dec_done) cwb_data_q <= dec_out_block[WORD_W-1:0];
    end
  end

  assign wb_valid = plain_pend_q | cwb_valid_q;
  assign wb_data  = plain_pend_q ? rd_word : cwb_data_q;

  logic _unused_bits;
  assign _unused_bits = &{1'b0, req_addr[WOFF_W-1:0], dec_out_block[BLK_W-1:WORD_W]};

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int BLK_W  = 64,
  parameter int WORD_W = 32,
  localparam int BE_W  = BLK_W / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             mem_en,
  input logic             mem_we,
  input logic [BE_W-1:0]  mem_be,
  input logic             enc_in_valid,
  input logic             enc_in_ready,
  input logic [BLK_W-1:0] enc_in_block,
  input logic             dec_in_valid,
  input logic             dec_in_ready,
  input logic [BLK_W-1:0] dec_in_block,
  input logic             wb_valid,
  input logic             ev_plain_rd,
  input logic             ev_enc_done,
  input logic             ev_dec_done
);

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_in_valid || dec_in_valid) |-> stall);

  // R8
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_in_valid && !enc_in_ready) |=> (enc_in_valid && $stable(enc_in_block)));

  // R8
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_valid && !dec_in_ready) |=> (dec_in_valid && $stable(dec_in_block)));

  // R8
  one_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enc_in_valid, dec_in_valid}));

  // R4
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enc_done |-> (mem_en && mem_we && (mem_be == '1) && !stall));

  // R1
  lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !ev_enc_done) |-> (($countones(mem_be) == WORD_W / 8) && !stall));

  // R2
  plain_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_plain_rd |=> wb_valid);

  // R5
  crypt_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dec_done |=> wb_valid);

endmodule

bind mem_crypt_stage mcs_checker #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_mcs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .mem_be       (mem_be),
  .enc_in_valid (enc_in_valid),
  .enc_in_ready (enc_in_ready),
  .enc_in_block (enc_in_block),
  .dec_in_valid (dec_in_valid),
  .dec_in_ready (dec_in_ready),
  .dec_in_block (dec_in_block),
  .wb_valid     (wb_valid),
  .ev_plain_rd  (ev_plain_rd),
  .ev_enc_done  (ev_enc_done),
  .ev_dec_done  (ev_dec_done)
);

// File: tb/mem_crypt_stage_test.sv
package tb_cipher_pkg;
  function automatic logic [63:0] rotl13(input logic [63:0] v);
    return {v[50:0], v[63:51]};
  endfunction
  function automatic logic [63:0] rotr13(input logic [63:0] v);
    return {v[12:0], v[63:13]};
  endfunction
  function automatic logic [63:0] toy_enc(input logic [63:0] b, input logic [63:0] k);
    return rotl13(b ^ k) + k;
  endfunction
  function automatic logic [63:0] toy_dec(input logic [63:0] c, input logic [63:0] k);
    return rotr13(c - k) ^ k;
  endfunction
endpackage

module tb_engine_model #(parameter bit DECRYPT = 1'b0) (
  input  logic        clk,
  input  logic        in_valid,
  input  logic [63:0] in_block,
  input  logic [63:0] key,
  input  int          gap,
  input  int          lat,
  output logic        in_ready,
  output logic        out_valid,
  output logic [63:0] out_block,
  output int          handshakes,
  output logic [63:0] seen_key,
  output logic [63:0] seen_block
);
  import tb_cipher_pkg::*;
  bit          busy;
  int          cnt;
  int          hold;
  logic [63:0] res;

  initial begin
    in_ready = 0; out_valid = 0; out_block = '0; handshakes = 0;
    seen_key = '0; seen_block = '0; busy = 0; cnt = 0; hold = 0; res = '0;
  end

  always @(negedge clk) begin
    out_valid = 1'b0;
    if (busy) begin
      if (cnt == 0) begin out_valid = 1'b1; out_block = res; busy = 0; end
      else cnt--;
    end
    in_ready = !busy && !out_valid && (hold >= gap);
    #2;
    if (in_valid && in_ready) begin
      busy = 1; cnt = lat; hold = 0; handshakes++;
      seen_key = key; seen_block = in_block;
      res = DECRYPT ? toy_dec(in_block, key) : toy_enc(in_block, key);
    end else if (in_valid) begin
      hold++;
    end
  end
endmodule

module mem_crypt_stage_test;
  import tb_cipher_pkg::*;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_load = 0, req_store = 0, req_crypt = 0, req_src_reg = 0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [63:0] req_key = '0;
  logic        stall, wb_valid, mem_en, mem_we;
  logic [31:0] wb_data, mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;
  logic        enc_in_valid, enc_in_ready, enc_out_valid;
  logic [63:0] enc_in_block, enc_out_block;
  logic        dec_in_valid, dec_in_ready, dec_out_valid;
  logic [63:0] dec_in_block, dec_out_block, cipher_key;
  int          enc_gap = 0, enc_lat = 0, dec_gap = 0, dec_lat = 0;
  int          enc_hs, dec_hs;
  logic [63:0] enc_seen_key, enc_seen_blk, dec_seen_key, dec_seen_blk;

  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic [63:0] mem_img [16];
  logic [31:0] exp_q [$];
  int          due_q [$];

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mem_crypt_stage uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
    .req_store(req_store), .req_crypt(req_crypt), .req_src_reg(req_src_reg),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_key(req_key),
    .stall(stall), .wb_valid(wb_valid), .wb_data(wb_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_block(enc_in_block),
    .enc_out_valid(enc_out_valid), .enc_out_block(enc_out_block),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_block(dec_in_block),
    .dec_out_valid(dec_out_valid), .dec_out_block(dec_out_block),
    .cipher_key(cipher_key)
  );

  tb_engine_model #(.DECRYPT(1'b0)) u_enc (
    .clk(clk), .in_valid(enc_in_valid), .in_block(enc_in_block), .key(cipher_key),
    .gap(enc_gap), .lat(enc_lat), .in_ready(enc_in_ready), .out_valid(enc_out_valid),
    .out_block(enc_out_block), .handshakes(enc_hs), .seen_key(enc_seen_key),
    .seen_block(enc_seen_blk)
  );

  tb_engine_model #(.DECRYPT(1'b1)) u_dec (
    .clk(clk), .in_valid(dec_in_valid), .in_block(dec_in_block), .key(cipher_key),
    .gap(dec_gap), .lat(dec_lat), .in_ready(dec_in_ready), .out_valid(dec_out_valid),
    .out_block(dec_out_block), .handshakes(dec_hs), .seen_key(dec_seen_key),
    .seen_block(dec_seen_blk)
  );

  // data memory: byte-masked writes, registered reads
  always @(posedge clk) begin
    if (mem_en && mem_we)
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mem_img[mem_addr[6:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    if (mem_en && !mem_we) mem_rdata <= mem_img[mem_addr[6:3]];
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // write-back monitor: every result must match the model and arrive on time
  always @(negedge clk) begin
    #4;
    if (rst_n && wb_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2/R5 unexpected wb", 64'(wb_data), 64'h0);
      else begin
        logic [31:0] e; int d;
        e = exp_q.pop_front(); d = due_q.pop_front();
        check(wb_data == e, "R2/R5 wb data", 64'(wb_data), 64'(e));
        check(cyc == d, "R2/R5 wb cycle", 64'(cyc), 64'(d));
      end
    end
  end

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0; req_load = 0; req_store = 0; req_crypt = 0; req_src_reg = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic run_op(input bit ld, input bit crypt, input bit src_reg,
                        input logic [31:0] addr, input logic [31:0] data,
                        input logic [63:0] key, input string tag);
    bit          cop = crypt && (ld || src_reg);
    int          enc0 = enc_hs, dec0 = dec_hs, n = 0, writes = 0;
    logic [3:0]  idx = addr[6:3];
    logic [31:0] alad = {addr[31:3], 3'b000};
    logic [31:0] exp_wb;
    logic [63:0] exp_blk;
    logic        exp_stall, exp_wr;
    @(negedge clk);
    req_valid = 1; req_load = ld; req_store = !ld; req_crypt = crypt;
    req_src_reg = src_reg; req_addr = addr; req_wdata = data; req_key = key;
    exp_wb = cop ? toy_dec(mem_img[idx], key)[31:0]
                 : (addr[2] ? mem_img[idx][63:32] : mem_img[idx][31:0]);
    forever begin
      #3;
      exp_stall = cop && !(ld ? dec_out_valid : enc_out_valid);
      check(stall == exp_stall, {"R6 stall ", tag}, 64'(stall), 64'(exp_stall));
      exp_wr = !ld && ((!cop && n == 0) || (cop && enc_out_valid));
      check((mem_en && mem_we) == exp_wr, {"R1/R4 write strobe ", tag},
            64'(mem_en && mem_we), 64'(exp_wr));
      if (exp_wr && mem_en && mem_we) begin
        writes++;
        check(mem_addr == alad, {"R4/R7 write addr ", tag}, 64'(mem_addr), 64'(alad));
        if (cop) begin
          exp_blk = toy_enc({32'h0, data}, key);
          check(mem_be == 8'hFF, {"R4 be ", tag}, 64'(mem_be), 64'hFF);
          check(mem_wdata == exp_blk, {"R4/R7 ciphertext ", tag}, mem_wdata, exp_blk);
        end else begin
          check(mem_be == (addr[2] ? 8'hF0 : 8'h0F), {"R1 be ", tag},
                64'(mem_be), addr[2] ? 64'hF0 : 64'h0F);
          check((addr[2] ? mem_wdata[63:32] : mem_wdata[31:0]) == data,
                {"R1 lane data ", tag},
                64'(addr[2] ? mem_wdata[63:32] : mem_wdata[31:0]), 64'(data));
        end
      end
      if (ld && n == 0)
        check(mem_en && !mem_we && mem_addr == alad, {"R2/R5 read issue ", tag},
              {mem_en, mem_we, mem_addr}, {2'b10, alad});
      if (!stall) break;
      n++;
      if (n > 400) begin check(1'b0, {"R6 stuck stall ", tag}, 64'(n), 64'd0); break; end
      @(negedge clk);
      if (n == 1 && cop) begin
        req_key = ~key; req_wdata = ~data; req_addr = addr ^ 32'h28;  // R7 scramble
      end
    end
    if (ld) begin exp_q.push_back(exp_wb); due_q.push_back(cyc + 1); end
    check(enc_hs - enc0 == int'(cop && !ld), {"R3/R4 enc requests ", tag},
          64'(enc_hs - enc0), 64'(cop && !ld));
    check(dec_hs - dec0 == int'(cop && ld), {"R5 dec requests ", tag},
          64'(dec_hs - dec0), 64'(cop && ld));
    if (!ld) check(writes == 1, {"R1/R4 one write ", tag}, 64'(writes), 64'd1);
    if (cop && !ld) begin
      check(enc_seen_key == key, {"R7 enc key ", tag}, enc_seen_key, key);
      check(enc_seen_blk == {32'h0, data}, {"R4 zero-extended block ", tag},
            enc_seen_blk, {32'h0, data});
    end
    if (cop && ld) begin
      check(dec_seen_key == key, {"R7 dec key ", tag}, dec_seen_key, key);
      check(dec_seen_blk == mem_img[idx], {"R5 dec block ", tag}, dec_seen_blk, mem_img[idx]);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++)
      mem_img[i] = {32'hA500_0000 + 32'(i * 7), 32'h5A00_0100 + 32'(i * 3)};
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    #3;
    // R9 reset state
    check(!stall && !wb_valid && !mem_en && !enc_in_valid && !dec_in_valid, "R9 reset",
          {59'h0, stall, wb_valid, mem_en, enc_in_valid, dec_in_valid}, 64'h0);
    @(negedge clk); rst_n = 1;
    idle(2);
    #3;
    check(!stall && !wb_valid && !mem_en, "R9 idle after reset",
          {61'h0, stall, wb_valid, mem_en}, 64'h0);

    // R1 plain stores, both lanes
    run_op(0, 0, 1, 32'h0000_0000, 32'h1111_2222, 64'h0, "st lane0");
    run_op(0, 0, 1, 32'h0000_000C, 32'h3333_4444, 64'h0, "st lane1");
    // R2 plain loads, back to back
    run_op(1, 0, 1, 32'h0000_0004, 32'h0, 64'h0, "ld lane1");
    run_op(1, 0, 0, 32'h0000_0008, 32'h0, 64'h0, "ld lane0");
    idle(2);
    // R3 cipher flag but immediate operand
    run_op(0, 1, 0, 32'h0000_0018, 32'hCAFE_F00D, 64'h0123_4567_89AB_CDEF, "st imm");
    run_op(1, 0, 0, 32'h0000_0018, 32'h0, 64'h0, "ld imm");
    // R4 cipher store, unaligned address, backpressure and latency
    enc_gap = 2; enc_lat = 3;
    run_op(0, 1, 1, 32'h0000_0014, 32'hDEAD_BEEF, 64'h4B49_5241_5450_414C, "cst");
    // R5 cipher load round trip
    run_op(1, 1, 1, 32'h0000_0010, 32'h0, 64'h4B49_5241_5450_414C, "cld");
    // R2 plain view of the ciphertext
    run_op(1, 0, 0, 32'h0000_0014, 32'h0, 64'h0, "ld ctext");
    // R5 with other key, immediate source, slow engine
    dec_gap = 4; dec_lat = 6;
    run_op(1, 1, 0, 32'h0000_0010, 32'h0, 64'hFFFF_0000_1234_5678, "cld key2");
    // plain load right before a cipher store
    run_op(1, 0, 1, 32'h0000_0028, 32'h0, 64'h0, "ld before cst");
    enc_gap = 0; enc_lat = 0; dec_gap = 0; dec_lat = 0;
    run_op(0, 1, 1, 32'h0000_0038, 32'h0000_0001, 64'h0F0F_F0F0_0000_FFFF, "cst fast");
    run_op(1, 1, 1, 32'h0000_003C, 32'h0, 64'h0F0F_F0F0_0000_FFFF, "cld fast");
    enc_gap = 5; enc_lat = 7;
    run_op(0, 1, 1, 32'h0000_0040, 32'h8000_0000, 64'hA5A5_5A5A_C3C3_3C3C, "cst slow");
    run_op(1, 1, 1, 32'h0000_0040, 32'h0, 64'hA5A5_5A5A_C3C3_3C3C, "cld slow");
    idle(4);
    check(exp_q.size() == 0, "R2/R5 all results returned", 64'(exp_q.size()), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule